// File: doc/BRIEF.md
# Per-Thread Cache Line Watch Tracker

This block keeps the watch state that lets several hardware threads of a data cache run optimistic, software-managed transactions. Next to each of the cache's lines it holds one watch bit per thread. A load-and-watch request marks a line as watched by the requesting thread. A write to that line by any other thread, or the line leaving the cache, raises a sticky per-thread "lost" flag. A check request returns that flag as a two-bit condition code one cycle later. Clearing drops either a single watch or, when the clear address is zero, every watch of the thread. A clear-all also reloads the lost flag from an operand bit.

The cache resolves addresses to line indices for watch, write-snoop and eviction inputs. Only the clear request carries a byte address, because address zero selects the clear-all form. A watch that the cache cannot place (no room for the block) cannot be tracked, so the thread's lost flag is raised instead.

Top module: `cache_watch_tracker`

## Requirements
- R1: After reset every lost flag is 0, `chk_rsp_vld` is 0 and `watch_rdy` is 1.
- R2: An accepted load-and-watch (`watch_vld && watch_rdy`, `watch_nofit` low) sets the requester's watch bit on `watch_line` at the next clock edge; one request can be accepted every cycle.
- R3: A write snoop (`wr_vld`) to a line by thread W sets, at the next edge, the lost flag of every thread other than W that watches that line; a thread's own writes and writes to unwatched lines leave flags unchanged.
- R4: A load-and-watch and a write by another thread to the same line in the same cycle leave the watcher's lost flag set.
- R5: A check (`chk_vld`, `chk_tid`) gives `chk_rsp_vld` high exactly one cycle later with `chk_cc` = 2'b10 if the requester's lost flag was set in the request cycle and 2'b01 otherwise; checks are accepted back to back.
- R6: An accepted load-and-watch with `watch_nofit` high sets no watch bit and sets the requester's lost flag.
- R7: A clear with `clr_addr` equal to zero clears all watch bits of `clr_tid` and loads its lost flag with `clr_l`, both effective at the second clock edge after the request; other threads are untouched.
- R8: `watch_rdy` is low when `watch_tid` has a clear-all in its request cycle or in the following cycle; a held request changes nothing, and requests from other threads proceed.
- R9: A clear with a nonzero address removes only the requester's watch on line `clr_addr[11:6]` (64-byte lines, 64 lines) at the next edge; if the same thread watches the same line in that cycle the watch remains.
- R10: An eviction (`evict_vld`) of a line sets the lost flag of every thread watching it and drops those watch bits at the next edge.
- R11: A set lost flag stays set through writes, watches, checks and single clears until a clear-all from its thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| watch_vld | input | 1 | Load-and-watch request valid |
| watch_tid | input | TID_W | Requesting thread |
| watch_line | input | IDX_W | Line to watch |
| watch_nofit | input | 1 | Cache could not place the block |
| watch_rdy | output | 1 | Watch request for `watch_tid` can be accepted |
| wr_vld | input | 1 | Write snoop valid |
| wr_tid | input | TID_W | Writing thread |
| wr_line | input | IDX_W | Line written |
| evict_vld | input | 1 | Line eviction valid |
| evict_line | input | IDX_W | Line evicted |
| chk_vld | input | 1 | Watch check request |
| chk_tid | input | TID_W | Checking thread |
| chk_rsp_vld | output | 1 | Check result valid |
| chk_cc | output | 2 | 2'b10 lost, 2'b01 intact |
| clr_vld | input | 1 | Clear request valid |
| clr_tid | input | TID_W | Clearing thread |
| clr_addr | input | ADDR_W | Byte address; zero means clear all |
| clr_l | input | 1 | Value loaded into the lost flag on clear-all |
| lost | output | NUM_THREADS | Sticky lost flag per thread |

## Verification
The bench aims at same-cycle collisions. A watch racing a remote write must report lost; a design that set the bit first and checked later would let that write slip by. A watch racing a single clear of the same line must keep the watch; a design that applied the clear last would drop it silently. A watch issued during or alongside a pending clear-all must be held and leave no bit behind, or a stale watch would outlive the flash clear. Nonzero clear addresses that map to line 0 must not be taken for clear-all. After an eviction, a later write to the dropped line must not raise the flag again.

// File: rtl/cache_watch_tracker.sv
`timescale 1ns/1ps
module cache_watch_tracker #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_LINES   = 64,
  parameter int LINE_BYTES  = 64,
  parameter int ADDR_W      = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           watch_vld,
  input  logic [$clog2(NUM_THREADS)-1:0] watch_tid,
  input  logic [$clog2(NUM_LINES)-1:0]   watch_line,
  input  logic                           watch_nofit,
  output logic                           watch_rdy,
  input  logic                           wr_vld,
  input  logic [$clog2(NUM_THREADS)-1:0] wr_tid,
  input  logic [$clog2(NUM_LINES)-1:0]   wr_line,
  input  logic                           evict_vld,
  input  logic [$clog2(NUM_LINES)-1:0]   evict_line,
  input  logic                           chk_vld,
  input  logic [$clog2(NUM_THREADS)-1:0] chk_tid,
  output logic                           chk_rsp_vld,
  output logic [1:0]                     chk_cc,
  input  logic                           clr_vld,
  input  logic [$clog2(NUM_THREADS)-1:0] clr_tid,
  input  logic [ADDR_W-1:0]              clr_addr,
  input  logic                           clr_l,
  output logic [NUM_THREADS-1:0]         lost
);
  localparam int TID_W = $clog2(NUM_THREADS);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [NUM_LINES-1:0]   watch_q [NUM_THREADS];
  logic [NUM_LINES-1:0]   watch_n [NUM_THREADS];
  logic [NUM_THREADS-1:0] lost_q, lost_n;
  logic [NUM_THREADS-1:0] pend_q, pend_n, pend_l_q;
  logic                   chk_lost_q;

  wire             clr_all  = clr_vld && (clr_addr == '0);
  wire             clr_one  = clr_vld && (clr_addr != '0);
  wire [IDX_W-1:0] clr_line = clr_addr[OFF_W +: IDX_W];

  assign watch_rdy = !(pend_q[watch_tid] || (clr_all && clr_tid == watch_tid));
  wire watch_go = watch_vld && watch_rdy;

  wire [NUM_LINES-1:0] set_oh = NUM_LINES'(1) << watch_line;
  wire [NUM_LINES-1:0] ev_oh  = evict_vld ? (NUM_LINES'(1) << evict_line) : '0;
  wire [NUM_LINES-1:0] clr_oh = NUM_LINES'(1) << clr_line;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    wire                 mine_set = watch_go && watch_tid == TID_W'(t);
    wire [NUM_LINES-1:0] set_m    = (mine_set && !watch_nofit) ? (set_oh & ~ev_oh) : '0;
    wire [NUM_LINES-1:0] clr_m    = (clr_one && clr_tid == TID_W'(t)) ? clr_oh : '0;
    wire hit_wr = wr_vld && wr_tid != TID_W'(t) &&
                  (watch_q[t][wr_line] || (mine_set && watch_line == wr_line));
    wire hit_ev = evict_vld &&
                  (watch_q[t][evict_line] || (mine_set && watch_line == evict_line));

    assign watch_n[t] = pend_q[t] ? '0 : ((watch_q[t] & ~clr_m & ~ev_oh) | set_m);
    assign lost_n[t]  = pend_q[t] ? pend_l_q[t]
                                  : (lost_q[t] | hit_wr | hit_ev | (mine_set && watch_nofit));
    assign pend_n[t]  = clr_all && clr_tid == TID_W'(t);

    AST_WR_MARKS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vld && wr_tid != TID_W'(t) && watch_q[t][wr_line] && !pend_q[t] |=> lost_q[t]); // R3
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lost_q[t] && !pend_q[t] |=> lost_q[t]); // R11
    AST_EVICT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      evict_vld && !pend_q[t] |=> !watch_q[t][$past(evict_line)]); // R10
    AST_CLEAR_LOADS_L: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[t] |=> (watch_q[t] == '0) && (lost_q[t] == $past(pend_l_q[t]))); // R7
    AST_NOFIT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      watch_vld && watch_rdy && watch_nofit && watch_tid == TID_W'(t) |=> lost_q[t]); // R6
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_THREADS; t++) watch_q[t] <= '0;
      lost_q      <= '0;
      pend_q      <= '0;
      pend_l_q    <= '0;
      chk_rsp_vld <= 1'b0;
      chk_lost_q  <= 1'b0;
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) watch_q[t] <= watch_n[t];
      lost_q      <= lost_n;
      pend_q      <= pend_n;
      if (clr_all) pend_l_q[clr_tid] <= clr_l;
      chk_rsp_vld <= chk_vld;
      chk_lost_q  <= lost_q[chk_tid];
    end
  end

  assign chk_cc = {chk_lost_q, !chk_lost_q};
  assign lost   = lost_q;

  AST_CHK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |=> chk_rsp_vld); // R5
endmodule

// File: tb/cache_watch_tracker_tb.sv
`timescale 1ns/1ps
module cache_watch_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       watch_vld = 0, watch_nofit = 0, wr_vld = 0, evict_vld = 0, chk_vld = 0, clr_vld = 0, clr_l = 0;
  logic [1:0] watch_tid = 0, wr_tid = 0, chk_tid = 0, clr_tid = 0;
  logic [5:0] watch_line = 0, wr_line = 0, evict_line = 0;
  logic [31:0] clr_addr = 0;
  logic       watch_rdy, chk_rsp_vld;
  logic [1:0] chk_cc;
  logic [3:0] lost;
  int n_run = 0, n_fail = 0;

  cache_watch_tracker dut_i (
    .clk(clk), .rst_n(rst_n),
    .watch_vld(watch_vld), .watch_tid(watch_tid), .watch_line(watch_line),
    .watch_nofit(watch_nofit), .watch_rdy(watch_rdy),
    .wr_vld(wr_vld), .wr_tid(wr_tid), .wr_line(wr_line),
    .evict_vld(evict_vld), .evict_line(evict_line),
    .chk_vld(chk_vld), .chk_tid(chk_tid), .chk_rsp_vld(chk_rsp_vld), .chk_cc(chk_cc),
    .clr_vld(clr_vld), .clr_tid(clr_tid), .clr_addr(clr_addr), .clr_l(clr_l),
    .lost(lost)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_v(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_watch(input int tid, input int line);
    watch_vld = 1; watch_tid = 2'(tid); watch_line = 6'(line); step(); watch_vld = 0;
  endtask
  task automatic do_write(input int tid, input int line);
    wr_vld = 1; wr_tid = 2'(tid); wr_line = 6'(line); step(); wr_vld = 0;
  endtask
  task automatic do_evict(input int line);
    evict_vld = 1; evict_line = 6'(line); step(); evict_vld = 0;
  endtask
  task automatic do_clear_one(input int tid, input int addr);
    clr_vld = 1; clr_tid = 2'(tid); clr_addr = 32'(addr); step(); clr_vld = 0;
  endtask
  task automatic do_clear_all(input int tid, input logic l);
    clr_vld = 1; clr_tid = 2'(tid); clr_addr = 0; clr_l = l; step(); clr_vld = 0; step();
  endtask
  task automatic clear_everyone();
    for (int t = 0; t < 4; t++) do_clear_all(t, 1'b0);
  endtask

  task automatic t_reset();
    watch_tid = 0;
    expect_v(lost, 4'b0000, "R1 lost after reset");
    expect_v({3'b0, chk_rsp_vld}, 4'b0000, "R1 rsp after reset");
    expect_v({3'b0, watch_rdy}, 4'b0001, "R1 rdy after reset");
  endtask

  task automatic t_remote_write();
    do_watch(0, 5);
    do_write(0, 5);
    expect_v(lost, 4'b0000, "R3 own write ignored");
    do_write(1, 6);
    expect_v(lost, 4'b0000, "R3 unwatched line ignored");
    do_write(1, 5);
    expect_v(lost, 4'b0001, "R2 R3 remote write marks watcher");
    chk_vld = 1; chk_tid = 0; step();
    expect_v({chk_rsp_vld, 1'b0, chk_cc}, 4'b1010, "R5 check lost thread");
    chk_tid = 1; step(); chk_vld = 0;
    expect_v({chk_rsp_vld, 1'b0, chk_cc}, 4'b1001, "R5 back-to-back check intact thread");
    step();
    expect_v({3'b0, chk_rsp_vld}, 4'b0000, "R5 no response without request");
    clr_vld = 1; clr_tid = 0; clr_addr = 0; clr_l = 0; step(); clr_vld = 0;
    watch_tid = 0;
    expect_v(lost, 4'b0001, "R7 flag unchanged one edge after clear-all");
    expect_v({3'b0, watch_rdy}, 4'b0000, "R8 rdy low while clear-all pending");
    step();
    expect_v(lost, 4'b0000, "R7 clear-all loads L=0");
    do_write(1, 5);
    expect_v(lost, 4'b0000, "R7 watch removed by clear-all");
  endtask

  task automatic t_sticky();
    do_watch(1, 9);
    do_write(0, 9);
    expect_v(lost, 4'b0010, "R11 flag set");
    do_watch(1, 12);
    do_clear_one(1, 9 * 64);
    step(); step();
    expect_v(lost, 4'b0010, "R11 flag survives watch, single clear, idle");
    do_clear_all(1, 1'b1);
    expect_v(lost, 4'b0010, "R7 clear-all loads L=1");
    do_clear_all(1, 1'b0);
    expect_v(lost, 4'b0000, "R7 clear-all loads L=0");
  endtask

  task automatic t_same_cycle();
    watch_vld = 1; watch_tid = 2; watch_line = 7;
    wr_vld = 1; wr_tid = 3; wr_line = 7;
    step(); watch_vld = 0; wr_vld = 0;
    expect_v(lost, 4'b0100, "R4 racing write flags new watch");
    do_clear_all(2, 1'b0);
    watch_nofit = 1; do_watch(3, 40); watch_nofit = 0;
    expect_v(lost, 4'b1000, "R6 unplaceable watch flags thread");
    do_clear_all(3, 1'b0);
    do_write(0, 40);
    expect_v(lost, 4'b0000, "R6 no bit left by unplaceable watch");
  endtask

  task automatic t_clear_one();
    do_watch(1, 10);
    do_watch(1, 11);
    do_clear_one(1, 10 * 64 + 3);
    do_write(0, 10);
    expect_v(lost, 4'b0000, "R9 single clear removes line");
    do_write(0, 11);
    expect_v(lost, 4'b0010, "R9 other line kept");
    do_watch(2, 0);
    do_clear_one(2, 4096);
    do_write(0, 0);
    expect_v(lost, 4'b0010, "R9 nonzero address on line 0 clears one");
    watch_vld = 1; watch_tid = 3; watch_line = 12;
    clr_vld = 1; clr_tid = 3; clr_addr = 12 * 64;
    step(); watch_vld = 0; clr_vld = 0;
    do_write(0, 12);
    expect_v(lost, 4'b1010, "R9 same-cycle watch survives clear");
    clear_everyone();
    expect_v(lost, 4'b0000, "R7 all cleared");
  endtask

  task automatic t_evict();
    do_watch(0, 20);
    do_watch(2, 20);
    do_watch(1, 21);
    do_evict(20);
    expect_v(lost, 4'b0101, "R10 eviction flags watchers only");
    do_clear_all(0, 1'b0);
    do_clear_all(2, 1'b0);
    do_write(3, 20);
    expect_v(lost, 4'b0000, "R10 no watch left on evicted line");
    do_write(3, 21);
    expect_v(lost, 4'b0010, "R10 other line unaffected");
    do_clear_all(1, 1'b0);
  endtask

  task automatic t_hold();
    clr_vld = 1; clr_tid = 1; clr_addr = 0; clr_l = 0;
    watch_vld = 1; watch_tid = 1; watch_line = 30;
    #1;
    expect_v({3'b0, watch_rdy}, 4'b0000, "R8 held in clear-all cycle");
    step(); clr_vld = 0;
    expect_v({3'b0, watch_rdy}, 4'b0000, "R8 held in pending cycle");
    watch_tid = 2; watch_line = 31; #1;
    expect_v({3'b0, watch_rdy}, 4'b0001, "R8 other thread proceeds");
    step(); watch_vld = 0; watch_tid = 1; #1;
    expect_v({3'b0, watch_rdy}, 4'b0001, "R8 ready again after clear");
    do_write(0, 30);
    expect_v(lost, 4'b0000, "R8 held watch not applied");
    do_write(0, 31);
    expect_v(lost, 4'b0100, "R2 R8 other thread watch applied");
    do_clear_all(2, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_remote_write();
    t_sticky();
    t_same_cycle();
    t_clear_one();
    t_evict();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule